// File: doc/BRIEF.md
# UART Interrupt and Threshold Controller

This block produces the nine interrupt sources of a UART whose transmit and receive queues hold up to 128 bytes each. It watches the two queue fill counts against programmable watermarks and receives one-cycle pulses for receive errors. It counts byte-time ticks to detect an idle receiver that still holds data, and it tracks edges on the two modem status inputs. Each source latches into a sticky raw bit. Software masks the raw bits with an enable register and clears them by writing ones to a clear address.

A small register port with one address bus serves both writes and reads. A write takes effect on the clock edge where `reg_wr` is high. `reg_rdata` follows `reg_addr` combinationally. The address map is: 0 raw (read only), 1 masked status (read only), 2 enable (read/write), 3 clear (write only, reads 0), 4 watermarks, 5 idle time-out configuration. The raw vector, the masked vector and their OR are also provided as outputs.

Top module: `uart_irq_ctrl`

## Requirements
- R1: Raw bit positions are: 0 receive level reached, 1 transmit level low, 2 parity error, 3 framing error, 4 receive overrun, 5 DSR edge, 6 CTS edge, 7 break error, 8 receive idle time-out. A source event sets its raw bit at the next clock edge. The bit then stays set until it is cleared, and it can be read at address 0.
- R2: Address 1 and `irq_status` give the raw bits ANDed bit by bit with the enable register. `irq_o` is high exactly when some status bit is set.
- R3: A write to address 3 clears every raw bit whose data bit is 1 and leaves the other raw bits unchanged.
- R4: When a source event and a clear of the same bit arrive in the same cycle, the bit ends up set.
- R5: Raw bit 0 is set in every cycle in which `rx_count` is greater than or equal to the receive watermark (address 4, bits 6:0).
- R6: Raw bit 1 is set in every cycle in which `tx_count` is below the transmit watermark (address 4, bits 14:8).
- R7: The idle counter advances once per `byte_tick`. It restarts on `rx_byte_p`, and it is held at zero while `rx_count` is 0 or the time-out is disabled (address 5 bit 7). Raw bit 8 is set once, on the tick that brings the count to the threshold (address 5 bits 6:0). A threshold of 0 never fires.
- R8: After a two-stage synchronizer, any rising or falling edge on `cts_i` sets raw bit 6, and any edge on `dsr_i` sets raw bit 5. The bit is set no more than three clock edges after the input changes.
- R9: Reset clears the raw and enable registers. Both watermarks reset to 0x60, and the time-out resets to disabled with threshold 0.
- R10: The enable register, the watermarks and the time-out configuration read back what was written. Address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_count | input | 8 | Receive queue fill count, 0 to 128 |
| tx_count | input | 8 | Transmit queue fill count, 0 to 128 |
| par_err_p | input | 1 | Parity error pulse |
| frm_err_p | input | 1 | Framing error pulse |
| rx_ovf_p | input | 1 | Receive overrun pulse |
| brk_err_p | input | 1 | Break / start error pulse |
| rx_byte_p | input | 1 | A byte was received |
| byte_tick | input | 1 | One byte time elapsed |
| cts_i | input | 1 | CTS line level, asynchronous |
| dsr_i | input | 1 | DSR line level, asynchronous |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address for read and write |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr` |
| irq_raw | output | 9 | Raw interrupt bits |
| irq_status | output | 9 | Raw bits masked by enables |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The receive watermark is tried one count below and exactly at its level, at the reset value and again after it is reprogrammed. The transmit watermark is tried at and one count below its level. These cases separate a greater-or-equal comparison from a strict one and show whether the programmed value is actually used. The idle time-out is driven with tick sequences that fall one short of the threshold, land exactly on it and run past it, with a received byte inserted in the middle, with an empty queue, with the time-out disabled and with a zero threshold. Together these distinguish a counter that restarts, saturates and fires once from one that is free-running or level-driven. The modem inputs are toggled in both directions, and a clear is issued in the same cycle as an error pulse to check that the event wins.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
    localparam int IRQ_N  = 9;
    localparam int CNT_W  = 8;
    localparam int THR_W  = 7;
    localparam int DATA_W = 16;
    localparam int ADDR_W = 3;

    // interrupt bit positions (software decodes these)
    localparam int B_RXLVL  = 0;
    localparam int B_TXLOW  = 1;
    localparam int B_PARITY = 2;
    localparam int B_FRAME  = 3;
    localparam int B_OVF    = 4;
    localparam int B_DSR    = 5;
    localparam int B_CTS    = 6;
    localparam int B_BRK    = 7;
    localparam int B_IDLE   = 8;

    localparam logic [ADDR_W-1:0] A_RAW  = 3'd0;
    localparam logic [ADDR_W-1:0] A_STAT = 3'd1;
    localparam logic [ADDR_W-1:0] A_ENA  = 3'd2;
    localparam logic [ADDR_W-1:0] A_CLR  = 3'd3;
    localparam logic [ADDR_W-1:0] A_LVL  = 3'd4;
    localparam logic [ADDR_W-1:0] A_IDLE = 3'd5;

    localparam int TXW_LSB  = 8;   // transmit watermark field offset
    localparam int IDLE_EN  = 7;   // idle time-out enable bit

    localparam logic [THR_W-1:0] WM_RST = 7'h60;

    typedef struct packed {
        logic [IRQ_N-1:0] raw;
        logic [IRQ_N-1:0] ena;
        logic [THR_W-1:0] rx_wm;
        logic [THR_W-1:0] tx_wm;
        logic             idle_en;
        logic [THR_W-1:0] idle_thr;
    } ctrl_t;
endpackage

// File: rtl/uirq_level_cmp.sv
module uirq_level_cmp #(
    parameter int CNT_W    = 8,
    parameter int THR_W    = 7,
    parameter bit AT_LEAST = 1'b1
) (
    input  logic [CNT_W-1:0] count_i,
    input  logic [THR_W-1:0] thr_i,
    output logic             hit_o
);
    localparam logic [CNT_W-1:0] PAD = '0;
    logic [CNT_W-1:0] thr_ext;

    always_comb begin
        thr_ext = PAD;
        thr_ext[THR_W-1:0] = thr_i;
    end

    generate
        if (AT_LEAST) begin : g_ge
            assign hit_o = (count_i >= thr_ext);
        end else begin : g_lt
            assign hit_o = (count_i < thr_ext);
        end
    endgenerate
endmodule

// File: rtl/uirq_idle_timer.sv
module uirq_idle_timer #(
    parameter int THR_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             empty_i,
    input  logic             byte_i,
    input  logic             tick_i,
    input  logic [THR_W-1:0] thr_i,
    output logic             fire_o
);
    localparam logic [THR_W-1:0] ONE = THR_W'(1);

    logic [THR_W-1:0] cnt_d, cnt_q;
    logic             live;

    always_comb begin
        live   = en_i && !empty_i && !byte_i;
        cnt_d  = cnt_q;
        fire_o = 1'b0;
        if (!live) begin
            cnt_d = '0;
        end else if (tick_i && (cnt_q != thr_i)) begin
            cnt_d  = cnt_q + ONE;
            fire_o = (cnt_q == thr_i - ONE);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/uirq_line_sync.sv
module uirq_line_sync #(
    parameter int LINES  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] lines_i,
    output logic [LINES-1:0] edge_o
);
    // STAGES synchronizer flops plus one history stage
    logic [STAGES:0][LINES-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d = {pipe_q[STAGES-1:0], lines_i};
        edge_o = pipe_q[STAGES] ^ pipe_q[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
    end
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
    import uart_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  rx_count,
    input  logic [CNT_W-1:0]  tx_count,
    input  logic              par_err_p,
    input  logic              frm_err_p,
    input  logic              rx_ovf_p,
    input  logic              brk_err_p,
    input  logic              rx_byte_p,
    input  logic              byte_tick,
    input  logic              cts_i,
    input  logic              dsr_i,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic [IRQ_N-1:0]  irq_raw,
    output logic [IRQ_N-1:0]  irq_status,
    output logic              irq_o
);
    ctrl_t st_d, st_q;

    logic             rx_hit, tx_hit, idle_fire;
    logic [1:0]       line_edge;   // [0] CTS, [1] DSR
    logic [IRQ_N-1:0] evt, clr;
    logic             unused_wbits;

    assign unused_wbits = ^reg_wdata;

    uirq_level_cmp #(.CNT_W(CNT_W), .THR_W(THR_W), .AT_LEAST(1'b1)) u_rx_cmp (
        .count_i(rx_count), .thr_i(st_q.rx_wm), .hit_o(rx_hit)
    );

    uirq_level_cmp #(.CNT_W(CNT_W), .THR_W(THR_W), .AT_LEAST(1'b0)) u_tx_cmp (
        .count_i(tx_count), .thr_i(st_q.tx_wm), .hit_o(tx_hit)
    );

    uirq_idle_timer #(.THR_W(THR_W)) u_idle (
        .clk(clk), .rst_n(rst_n), .en_i(st_q.idle_en),
        .empty_i(rx_count == '0), .byte_i(rx_byte_p), .tick_i(byte_tick),
        .thr_i(st_q.idle_thr), .fire_o(idle_fire)
    );

    uirq_line_sync #(.LINES(2), .STAGES(2)) u_lines (
        .clk(clk), .rst_n(rst_n), .lines_i({dsr_i, cts_i}), .edge_o(line_edge)
    );

    always_comb begin
        evt           = '0;
        evt[B_RXLVL]  = rx_hit;
        evt[B_TXLOW]  = tx_hit;
        evt[B_PARITY] = par_err_p;
        evt[B_FRAME]  = frm_err_p;
        evt[B_OVF]    = rx_ovf_p;
        evt[B_DSR]    = line_edge[1];
        evt[B_CTS]    = line_edge[0];
        evt[B_BRK]    = brk_err_p;
        evt[B_IDLE]   = idle_fire;

        st_d = st_q;
        clr  = '0;
        if (reg_wr) begin
            case (reg_addr)
                A_ENA:  st_d.ena = reg_wdata[IRQ_N-1:0];
                A_CLR:  clr = reg_wdata[IRQ_N-1:0];
                A_LVL: begin
                    st_d.rx_wm = reg_wdata[THR_W-1:0];
                    st_d.tx_wm = reg_wdata[TXW_LSB +: THR_W];
                end
                A_IDLE: begin
                    st_d.idle_en  = reg_wdata[IDLE_EN];
                    st_d.idle_thr = reg_wdata[THR_W-1:0];
                end
                default: ;
            endcase
        end
        // a new event overrides a simultaneous clear
        st_d.raw = (st_q.raw & ~clr) | evt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{raw: '0, ena: '0, rx_wm: WM_RST, tx_wm: WM_RST,
                      idle_en: 1'b0, idle_thr: '0};
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        irq_raw    = st_q.raw;
        irq_status = st_q.raw & st_q.ena;
        irq_o      = |irq_status;
        reg_rdata  = '0;
        case (reg_addr)
            A_RAW:  reg_rdata[IRQ_N-1:0] = irq_raw;
            A_STAT: reg_rdata[IRQ_N-1:0] = irq_status;
            A_ENA:  reg_rdata[IRQ_N-1:0] = st_q.ena;
            A_LVL: begin
                reg_rdata[THR_W-1:0]         = st_q.rx_wm;
                reg_rdata[TXW_LSB +: THR_W]  = st_q.tx_wm;
            end
            A_IDLE: begin
                reg_rdata[THR_W-1:0] = st_q.idle_thr;
                reg_rdata[IDLE_EN]   = st_q.idle_en;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/uart_irq_ctrl_sva.sv
module uart_irq_ctrl_sva
    import uart_irq_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic              par_err_p,
    input logic              frm_err_p,
    input logic [CNT_W-1:0]  rx_count,
    input logic [CNT_W-1:0]  tx_count,
    input logic [THR_W-1:0]  rx_wm,
    input logic [THR_W-1:0]  tx_wm,
    input logic [IRQ_N-1:0]  irq_raw,
    input logic [IRQ_N-1:0]  irq_status
);
    logic clr_wr;
    assign clr_wr = reg_wr && (reg_addr == A_CLR);

    p_err_sets_r1: assert property (@(posedge clk) disable iff (!rst_n)
        par_err_p |=> irq_raw[B_PARITY]);

    p_raw_sticky_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_wr |=> ((irq_raw & $past(irq_raw)) == $past(irq_raw)));

    p_status_subset_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_status & ~irq_raw) == '0);

    p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && reg_wdata[B_PARITY] && !par_err_p) |=> !irq_raw[B_PARITY]);

    p_event_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && reg_wdata[B_FRAME] && frm_err_p) |=> irq_raw[B_FRAME]);

    p_rx_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_count >= CNT_W'(rx_wm)) |=> irq_raw[B_RXLVL]);

    p_tx_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_count < CNT_W'(tx_wm)) |=> irq_raw[B_TXLOW]);
endmodule

bind uart_irq_ctrl uart_irq_ctrl_sva u_sva (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .par_err_p(par_err_p), .frm_err_p(frm_err_p),
    .rx_count(rx_count), .tx_count(tx_count),
    .rx_wm(st_q.rx_wm), .tx_wm(st_q.tx_wm),
    .irq_raw(irq_raw), .irq_status(irq_status)
);

// File: tb/uart_irq_ctrl_tb_top.sv
module uart_irq_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  rx_count = '0, tx_count = '0;
    logic        par_err_p = 0, frm_err_p = 0, rx_ovf_p = 0, brk_err_p = 0;
    logic        rx_byte_p = 0, byte_tick = 0, cts_i = 0, dsr_i = 0;
    logic        reg_wr = 0;
    logic [2:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic [8:0]  irq_raw, irq_status;
    logic        irq_o;

    int n_total = 0;
    int n_fail  = 0;
    bit done    = 0;

    typedef struct {
        bit          is_irq;
        logic [15:0] exp;
        string       tag;
    } item_t;
    item_t sb[$];

    always #5 clk = ~clk;

    uart_irq_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .rx_count(rx_count), .tx_count(tx_count),
        .par_err_p(par_err_p), .frm_err_p(frm_err_p), .rx_ovf_p(rx_ovf_p),
        .brk_err_p(brk_err_p), .rx_byte_p(rx_byte_p), .byte_tick(byte_tick),
        .cts_i(cts_i), .dsr_i(dsr_i), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_raw(irq_raw),
        .irq_status(irq_status), .irq_o(irq_o)
    );

    // monitor: compares queued expectations shortly after the falling edge
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (sb.size() > 0) begin
                item_t it;
                logic [15:0] got;
                it  = sb.pop_front();
                got = it.is_irq ? {15'b0, irq_o} : reg_rdata;
                n_total++;
                if (got !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s: got %h expected %h", it.tag, got, it.exp);
                end
            end
        end
    end

    task automatic chk(input logic [2:0] a, input logic [15:0] e, input string tag);
        @(negedge clk);
        reg_addr = a;
        sb.push_back('{1'b0, e, tag});
    endtask

    task automatic chk_irq(input logic e, input string tag);
        @(negedge clk);
        sb.push_back('{1'b1, {15'b0, e}, tag});
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic pulse(input int which);
        @(negedge clk);
        case (which)
            0: par_err_p = 1;
            1: frm_err_p = 1;
            2: rx_ovf_p  = 1;
            3: brk_err_p = 1;
            default: rx_byte_p = 1;
        endcase
        @(negedge clk);
        par_err_p = 0; frm_err_p = 0; rx_ovf_p = 0; brk_err_p = 0; rx_byte_p = 0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); byte_tick = 1;
            @(negedge clk); byte_tick = 0;
        end
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_total++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_total - n_fail, n_total);
            $finish;
        end
    end

    initial begin
        // R9 reset state
        chk(0, 16'h0000, "R9 raw at reset");
        chk(2, 16'h0000, "R9 enable at reset");
        chk(4, 16'h6060, "R9 watermarks at reset");
        chk(5, 16'h0000, "R9 idle config at reset");
        chk_irq(1'b0, "R9 irq at reset");
        @(negedge clk); rst_n = 1;

        // R6 transmit low with empty queue, R2 masked off
        chk(0, 16'h0002, "R6 tx low at count 0");
        chk_irq(1'b0, "R2 irq masked");
        wr(3, 16'h0002);
        chk(0, 16'h0002, "R4 persistent level beats clear");
        tx_count = 8'h60;
        wr(3, 16'h0002);
        chk(0, 16'h0000, "R3 clear tx low at watermark");
        tx_count = 8'h5F; settle(1);
        chk(0, 16'h0002, "R6 tx low one below watermark");
        tx_count = 8'h60;
        wr(3, 16'h0002);

        // R5 receive watermark boundary
        rx_count = 8'h5F; settle(1);
        chk(0, 16'h0000, "R5 rx one below watermark");
        rx_count = 8'h60; settle(1);
        chk(0, 16'h0001, "R5 rx at watermark");
        rx_count = 8'h00;
        wr(3, 16'h0001);
        chk(0, 16'h0000, "R3 clear rx level");

        // R1 error pulses
        pulse(0); chk(0, 16'h0004, "R1 parity bit 2");
        pulse(1); chk(0, 16'h000C, "R1 framing bit 3");
        pulse(2); chk(0, 16'h001C, "R1 overrun bit 4");
        pulse(3); chk(0, 16'h009C, "R1 break bit 7");
        wr(3, 16'h0014);
        chk(0, 16'h0088, "R3 partial clear");
        wr(2, 16'h0008);
        chk(1, 16'h0008, "R2 status masked");
        chk_irq(1'b1, "R2 irq asserted");
        wr(2, 16'h0004);
        chk(1, 16'h0000, "R2 status after enable change");
        chk_irq(1'b0, "R2 irq deasserted");
        chk(2, 16'h0004, "R10 enable readback");
        chk(3, 16'h0000, "R10 clear address reads zero");

        // R4 event and clear in the same cycle
        wr(3, 16'h0008);
        chk(0, 16'h0080, "R3 clear framing");
        @(negedge clk);
        frm_err_p = 1; reg_wr = 1; reg_addr = 3; reg_wdata = 16'h0008;
        @(negedge clk);
        frm_err_p = 0; reg_wr = 0;
        chk(0, 16'h0088, "R4 event wins over clear");
        wr(3, 16'h01FF);
        chk(0, 16'h0000, "R3 clear all");

        // R8 modem line edges both ways
        cts_i = 1; settle(4);
        chk(0, 16'h0040, "R8 CTS rising");
        wr(3, 16'h0040);
        cts_i = 0; settle(4);
        chk(0, 16'h0040, "R8 CTS falling");
        wr(3, 16'h0040);
        dsr_i = 1; settle(4);
        chk(0, 16'h0020, "R8 DSR rising");
        wr(3, 16'h0020);
        chk(0, 16'h0000, "R8 quiet after clear");

        // R5 programmed watermark
        wr(4, 16'h1005);
        chk(4, 16'h1005, "R10 watermark readback");
        rx_count = 8'd5; settle(1);
        chk(0, 16'h0001, "R5 programmed watermark hit");
        rx_count = 8'd4;
        wr(3, 16'h0001);
        chk(0, 16'h0000, "R5 below programmed watermark");

        // R7 idle time-out
        wr(5, 16'h0083);
        chk(5, 16'h0083, "R10 idle config readback");
        pulse(4); ticks(2);
        chk(0, 16'h0000, "R7 two ticks of three");
        ticks(1);
        chk(0, 16'h0100, "R7 fires at threshold");
        wr(3, 16'h0100); ticks(3);
        chk(0, 16'h0000, "R7 one-shot after firing");
        pulse(4); ticks(2); pulse(4); ticks(2);
        chk(0, 16'h0000, "R7 byte restarts count");
        ticks(1);
        chk(0, 16'h0100, "R7 fires after restart");
        wr(3, 16'h0100);
        rx_count = 8'd0; ticks(5);
        chk(0, 16'h0000, "R7 held while queue empty");
        rx_count = 8'd4;
        wr(5, 16'h0003); ticks(5);
        chk(0, 16'h0000, "R7 disabled");
        wr(5, 16'h0080); pulse(4); ticks(5);
        chk(0, 16'h0000, "R7 zero threshold never fires");

        settle(2);
        done = 1;
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end
endmodule